// File: doc/BRIEF.md
# Predictive Delay-Chain Controller with Doublet Readout Decoder

This block is the digital part of a time-to-digital converter that predicts where the next feedback edge will fall. It works once per reference period. While the reference is low, it takes the fractional reference phase and an estimate of the converter gain. The gain is the unit cell delay divided by the feedback period. From these two values it computes how many delay cells the reference edge must cross, which is (1 − fraction) / gain, saturated to the length of the chain. That count becomes a 64-bit control mask. The mask can be rotated by a start offset so that the cells used change from cycle to cycle. The mask and the reference level together produce pull-up and pull-down enables for every cell node. These enables follow the reset, set and propagation phases of each period.

The gated feedback clock samples a short readout of 8 taps. The block decodes those bits by finding the single place where two neighbouring taps hold the same value. That place marks where the edge has reached. The block reports it as a 3-bit code and also scales it by the gain to give a fractional phase error. A readout with no such place, or with several, is flagged as an error and the previous code is kept.

Top module: `lookahead_ctrl`

## Requirements
- R1: While `ref_in` is low, the delay count is latched as floor((65536 − `frac_in`) / (16 · `gain_in`)), saturated to 63. A `gain_in` of zero gives 63. The value shows on `delay_cnt` one clock later.
- R2: Build an unrotated mask with bits [63 : 64−count] at 0 and all lower bits at 1. `cell_mask` is this mask rotated toward the MSB by the latched `rot_in`, so bit (k + rot) mod 64 of `cell_mask` equals bit k of the unrotated mask.
- R3: `phase_o` is encoded as 0 = reset, 1 = set, 2 = propagate. After a clock edge that samples `ref_in` low, it is 0. After the first edge that samples `ref_in` high, it is 1 for exactly one cycle. It is then 2 for as long as `ref_in` stays high.
- R4: In the reset phase every node is forced. Even nodes are pulled down (`cell_pd`) and odd nodes are pulled up (`cell_pu`).
- R5: In the set phase each node whose mask bit is 1 is driven to the inverse of its reset value: pull-up on even nodes, pull-down on odd nodes. Nodes whose mask bit is 0 have both enables off, so they float.
- R6: In the propagate phase all pull-up and pull-down enables are off.
- R7: No node ever has its pull-up and pull-down enabled at the same time.
- R8: One cycle after `tap_valid`, `code_vld` pulses high. If exactly one index i in 0..6 has `taps_in[i]` equal to `taps_in[i+1]`, then `code` equals i and `code_err` is 0.
- R9: If the sampled taps have no equal neighbouring pair, or more than one, `code_err` is 1 and `code` keeps its previous value.
- R10: `phase_err` equals `code` multiplied by the gain latched for the current period. Its format is an unsigned value with 12 fraction bits.
- R11: After reset, the phase is reset, the count and rotation are 0, and `code`, `code_err`, `code_vld` and `phase_err` are 0.
- R12: Changes to `frac_in`, `gain_in` or `rot_in` while `ref_in` is high affect neither `delay_cnt` nor `cell_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference level, sampled synchronously |
| frac_in | input | 16 | Fractional reference phase, unsigned fraction of one |
| gain_in | input | 12 | Converter gain estimate, unsigned Q0.12 |
| rot_in | input | 6 | Start-cell rotation offset |
| taps_in | input | 8 | Captured readout flip-flop values |
| tap_valid | input | 1 | Strobe marking a fresh readout sample |
| phase_o | output | 2 | Current phase: 0 reset, 1 set, 2 propagate |
| delay_cnt | output | 6 | Latched delay cell count |
| cell_mask | output | 64 | Rotated pseudo-thermometer control mask |
| cell_pu | output | 64 | Per-node pull-up enables |
| cell_pd | output | 64 | Per-node pull-down enables |
| code | output | 3 | Decoded doublet position |
| code_err | output | 1 | Readout had zero or several doublets |
| code_vld | output | 1 | One-cycle strobe for a new decode |
| phase_err | output | 15 | Normalized phase error, code times gain |

## Verification
The bench uses the default build: 64 cells, 8 taps, a 16-bit fraction and a 12-bit gain. With 8 taps there are only 256 readout patterns, so every pattern is decoded, and each one is checked for a unique doublet, for no doublet and for several doublets, with the held code and its normalized error tracked throughout. The 64-cell chain is small enough to predict each mask bit and each pull enable for every period. The sweep covers gains from zero through full scale and fractions from 0 to 65535. That range reaches both the saturated count of 63 and counts near zero, and the rotation offset wraps across the whole chain.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        LA_RESET = 2'd0,
        LA_SET   = 2'd1,
        LA_PROP  = 2'd2
    } la_phase_e;

endpackage

// File: rtl/la_delay_div.sv
// Restoring divider: count = (2^FRAC_W - frac) / (gain << (FRAC_W - GAIN_W)),
// saturated to 2^CNT_W - 1.
module la_delay_div #(
    parameter int FRAC_W = 16,
    parameter int GAIN_W = 12,
    parameter int CNT_W  = 6
) (
    input  logic [FRAC_W-1:0] frac,
    input  logic [GAIN_W-1:0] gain,
    output logic [CNT_W-1:0]  cnt
);
    localparam int SHIFT = FRAC_W - GAIN_W;
    localparam int WW    = FRAC_W + CNT_W + 2;

    logic [WW-1:0] num;
    logic [WW-1:0] den;
    logic [WW-1:0] rem [CNT_W+1];
    logic [CNT_W-1:0] quo;
    logic          sat;

    always_comb begin
        num = (WW'(1) << FRAC_W) - WW'(frac);
        den = WW'(gain) << SHIFT;
        sat = (gain == '0) || (num >= (den << CNT_W));
    end

    assign rem[CNT_W] = num;

    for (genvar i = CNT_W - 1; i >= 0; i--) begin : g_stage
        logic [WW-1:0] trial;
        assign trial  = den << i;
        assign quo[i] = (rem[i+1] >= trial);
        assign rem[i] = quo[i] ? (rem[i+1] - trial) : rem[i+1];
    end

    assign cnt = sat ? {CNT_W{1'b1}} : quo;

endmodule

// File: rtl/la_cell_ctl.sv
// Per-node mask and set/reset drive generation.
module la_cell_ctl
    import la_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int CELLS = 1 << CNT_W
) (
    input  la_phase_e         phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  rot,
    output logic [CELLS-1:0]  mask,
    output logic [CELLS-1:0]  pu,
    output logic [CELLS-1:0]  pd
);
    logic [CNT_W:0] ones_len;
    assign ones_len = (CNT_W+1)'(CELLS) - {1'b0, cnt};

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        logic [CNT_W-1:0] src;
        assign src     = CNT_W'(j) - rot;
        assign mask[j] = ({1'b0, src} < ones_len);

        if (j % 2 == 0) begin : g_even
            always_comb begin
                unique case (phase)
                    LA_RESET: begin pu[j] = 1'b0;    pd[j] = 1'b1; end
                    LA_SET:   begin pu[j] = mask[j]; pd[j] = 1'b0; end
                    default:  begin pu[j] = 1'b0;    pd[j] = 1'b0; end
                endcase
            end
        end else begin : g_odd
            always_comb begin
                unique case (phase)
                    LA_RESET: begin pu[j] = 1'b1; pd[j] = 1'b0;    end
                    LA_SET:   begin pu[j] = 1'b0; pd[j] = mask[j]; end
                    default:  begin pu[j] = 1'b0; pd[j] = 1'b0;    end
                endcase
            end
        end
    end

endmodule

// File: rtl/la_doublet_dec.sv
// Locates equal adjacent tap pairs; reports the position when it is unique.
module la_doublet_dec #(
    parameter int TAPS   = 8,
    localparam int CODE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   taps,
    output logic [CODE_W-1:0] pos,
    output logic              single
);
    localparam int PAIRS = TAPS - 1;
    localparam int NW    = $clog2(TAPS) + 1;

    logic [PAIRS-1:0] hit;

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign hit[i] = ~(taps[i] ^ taps[i+1]);
    end

    always_comb begin
        logic [NW-1:0] n;
        n   = '0;
        pos = '0;
        for (int i = 0; i < PAIRS; i++) begin
            if (hit[i]) begin
                n   = n + NW'(1);
                pos = CODE_W'(i);
            end
        end
        single = (n == NW'(1));
    end

endmodule

// File: rtl/lookahead_ctrl.sv
module lookahead_ctrl
    import la_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int GAIN_W = 12,
    parameter int CNT_W  = 6,
    parameter int TAPS   = 8,
    localparam int CELLS  = 1 << CNT_W,
    localparam int CODE_W = $clog2(TAPS),
    localparam int PE_W   = CODE_W + GAIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic [CNT_W-1:0]  rot_in,
    input  logic [TAPS-1:0]   taps_in,
    input  logic              tap_valid,
    output logic [1:0]        phase_o,
    output logic [CNT_W-1:0]  delay_cnt,
    output logic [CELLS-1:0]  cell_mask,
    output logic [CELLS-1:0]  cell_pu,
    output logic [CELLS-1:0]  cell_pd,
    output logic [CODE_W-1:0] code,
    output logic              code_err,
    output logic              code_vld,
    output logic [PE_W-1:0]   phase_err
);
    typedef struct packed {
        la_phase_e         phase;
        logic              ref_seen;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rot;
        logic [GAIN_W-1:0] gain;
        logic [CODE_W-1:0] code;
        logic              err;
        logic              vld;
        logic [PE_W-1:0]   pe;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]  div_cnt;
    logic [CODE_W-1:0] dec_pos;
    logic              dec_single;

    la_delay_div #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W)) u_div (
        .frac (frac_in),
        .gain (gain_in),
        .cnt  (div_cnt)
    );

    la_doublet_dec #(.TAPS(TAPS)) u_dec (
        .taps   (taps_in),
        .pos    (dec_pos),
        .single (dec_single)
    );

    la_cell_ctl #(.CNT_W(CNT_W)) u_cells (
        .phase (st_q.phase),
        .cnt   (st_q.cnt),
        .rot   (st_q.rot),
        .mask  (cell_mask),
        .pu    (cell_pu),
        .pd    (cell_pd)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ref_seen = ref_in;
        st_d.vld      = 1'b0;

        if (!ref_in) begin
            st_d.phase = LA_RESET;
            st_d.cnt   = div_cnt;
            st_d.rot   = rot_in;
            st_d.gain  = gain_in;
        end else if (!st_q.ref_seen) begin
            st_d.phase = LA_SET;
        end else begin
            st_d.phase = LA_PROP;
        end

        if (tap_valid) begin
            st_d.vld = 1'b1;
            st_d.err = !dec_single;
            if (dec_single) begin
                st_d.code = dec_pos;
            end
        end

        st_d.pe = PE_W'(st_d.code) * PE_W'(st_d.gain);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: LA_RESET, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign delay_cnt = st_q.cnt;
    assign code      = st_q.code;
    assign code_err  = st_q.err;
    assign code_vld  = st_q.vld;
    assign phase_err = st_q.pe;

endmodule

// File: rtl/lookahead_ctrl_chk.sv
module lookahead_ctrl_chk #(
    parameter int CNT_W  = 6,
    parameter int CODE_W = 3,
    localparam int CELLS = 1 << CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_in,
    input logic              tap_valid,
    input logic [1:0]        phase_o,
    input logic [CNT_W-1:0]  delay_cnt,
    input logic [CELLS-1:0]  cell_mask,
    input logic [CELLS-1:0]  cell_pu,
    input logic [CELLS-1:0]  cell_pd,
    input logic [CODE_W-1:0] code,
    input logic              code_err,
    input logic              code_vld
);
    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_pu & cell_pd) == '0);

    // R4
    reset_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd0 |-> &(cell_pu | cell_pd));

    // R5
    set_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd1 |-> (cell_pu | cell_pd) == cell_mask);

    // R6
    prop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd2 |-> (cell_pu | cell_pd) == '0);

    // R3
    ref_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_in |=> phase_o == 2'd0);

    // R3
    set_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd1 |=> phase_o != 2'd1);

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_in |=> $stable(delay_cnt) && $stable(cell_mask));

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |=> code_vld);

    // R8
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_valid |=> !code_vld);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld && code_err |-> code == $past(code));
endmodule

bind lookahead_ctrl lookahead_ctrl_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .tap_valid (tap_valid),
    .phase_o   (phase_o),
    .delay_cnt (delay_cnt),
    .cell_mask (cell_mask),
    .cell_pu   (cell_pu),
    .cell_pd   (cell_pd),
    .code      (code),
    .code_err  (code_err),
    .code_vld  (code_vld)
);

// File: tb/tb_lookahead_ctrl.sv
module tb_lookahead_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] EVEN_BITS = 64'h5555_5555_5555_5555;
    localparam logic [63:0] ODD_BITS  = 64'hAAAA_AAAA_AAAA_AAAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic [15:0] frac_in = '0;
    logic [11:0] gain_in = '0;
    logic [5:0]  rot_in = '0;
    logic [7:0]  taps_in = '0;
    logic        tap_valid = 1'b0;
    logic [1:0]  phase_o;
    logic [5:0]  delay_cnt;
    logic [63:0] cell_mask, cell_pu, cell_pd;
    logic [2:0]  code;
    logic        code_err, code_vld;
    logic [14:0] phase_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    lookahead_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .frac_in(frac_in),
        .gain_in(gain_in), .rot_in(rot_in), .taps_in(taps_in),
        .tap_valid(tap_valid), .phase_o(phase_o), .delay_cnt(delay_cnt),
        .cell_mask(cell_mask), .cell_pu(cell_pu), .cell_pd(cell_pd),
        .code(code), .code_err(code_err), .code_vld(code_vld),
        .phase_err(phase_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int exp_count(input int frac, input int gain);
        int q;
        if (gain == 0) return 63;
        q = (65536 - frac) / (gain * 16);
        return (q > 63) ? 63 : q;
    endfunction

    function automatic logic [63:0] exp_mask(input int cnt, input int rot);
        logic [63:0] base, m;
        for (int k = 0; k < 64; k++) base[k] = (k < 64 - cnt);
        for (int k = 0; k < 64; k++) m[(k + rot) % 64] = base[k];
        return m;
    endfunction

    int cur_gain = 0;
    int last_code = 0;

    task automatic apply_period(input int frac, input int gain, input int rot);
        int ec;
        logic [63:0] em;
        @(negedge clk);
        ref_in = 1'b0; frac_in = 16'(frac); gain_in = 12'(gain); rot_in = 6'(rot);
        @(negedge clk);
        ec = exp_count(frac, gain);
        em = exp_mask(ec, rot);
        cur_gain = gain;
        chk(phase_o == 2'd0, "R3", "reset phase", 64'(phase_o), 64'd0);
        chk(delay_cnt == 6'(ec), "R1", "delay count", 64'(delay_cnt), 64'(ec));
        chk(cell_pu == ODD_BITS && cell_pd == EVEN_BITS, "R4", "reset drive",
            cell_pu, ODD_BITS);
        ref_in = 1'b1;
        @(negedge clk);
        chk(phase_o == 2'd1, "R3", "set phase", 64'(phase_o), 64'd1);
        chk(cell_mask == em, "R2", "mask", cell_mask, em);
        chk(cell_pu == (em & EVEN_BITS) && cell_pd == (em & ODD_BITS), "R5",
            "set drive", cell_pu | cell_pd, em);
        chk((cell_pu & cell_pd) == '0, "R7", "contention", cell_pu & cell_pd, 64'd0);
        frac_in = ~16'(frac); gain_in = ~12'(gain); rot_in = ~6'(rot);
        @(negedge clk);
        chk(phase_o == 2'd2, "R3", "prop phase", 64'(phase_o), 64'd2);
        chk(delay_cnt == 6'(ec), "R12", "count held", 64'(delay_cnt), 64'(ec));
        chk(cell_mask == em, "R12", "mask held", cell_mask, em);
        chk(cell_pu == '0 && cell_pd == '0, "R6", "prop release",
            cell_pu | cell_pd, 64'd0);
    endtask

    task automatic decode_one(input int t);
        int n, p;
        int epe;
        n = 0; p = 0;
        for (int i = 0; i < 7; i++) begin
            if (t[i] == t[i+1]) begin n++; p = i; end
        end
        @(negedge clk);
        taps_in = 8'(t); tap_valid = 1'b1;
        @(negedge clk);
        tap_valid = 1'b0;
        chk(code_vld == 1'b1, "R8", "valid strobe", 64'(code_vld), 64'd1);
        if (n == 1) begin
            last_code = p;
            chk(code_err == 1'b0 && code == 3'(p), "R8", "unique doublet",
                {code_err, 3'd0, 1'b0, code}, 64'(p));
        end else begin
            chk(code_err == 1'b1 && code == 3'(last_code), "R9", "bad readout hold",
                {code_err, 3'd0, 1'b0, code}, {59'd1, 5'(last_code)});
        end
        epe = last_code * cur_gain;
        chk(phase_err == 15'(epe), "R10", "normalized error", 64'(phase_err), 64'(epe));
        @(negedge clk);
        chk(code_vld == 1'b0, "R8", "strobe one cycle", 64'(code_vld), 64'd0);
    endtask

    initial begin
        int gains [12] = '{0, 1, 2, 7, 16, 64, 100, 256, 1000, 2047, 3000, 4095};
        int vec;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(phase_o == 2'd0 && delay_cnt == '0, "R11", "reset phase/count",
            {58'd0, phase_o, 4'd0}, 64'd0);
        chk(code == '0 && !code_err && !code_vld && phase_err == '0, "R11",
            "reset decode", 64'(phase_err), 64'd0);
        rst_n = 1'b1;
        vec = 0;
        foreach (gains[g]) begin
            for (int f = 0; f < 65536; f += 4099) begin
                apply_period(f, gains[g], (vec * 13) % 64);
                vec++;
            end
            apply_period(65535, gains[g], (vec * 13) % 64);
            vec++;
        end
        apply_period(0, 300, 37);
        for (int t = 0; t < 256; t++) begin
            if (t == 128) apply_period(12345, 2500, 5);
            decode_one(t);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule